// File: doc/BRIEF.md
# Discontinuous Receive Wake Sequencer

This block is the low-power polling controller of a radio receiver. While polling mode is enabled it repeats a wake cycle made of three chained timed phases. The dark phase keeps every receiver section unpowered. In the host recovery phase the block pulls the shared open-drain wake line low so that a sleeping host can start itself. In the settle phase the selected receiver sections power up, with the peak detectors held back, and the line stays pulled low. All timers advance on a common 120 µs base tick. The dark phase length is a 16-bit count scaled by one of four time bases. The recovery phase is an 8-bit count of base ticks, and the settle phase is a 16-bit count of base ticks.

When the settle phase ends, the block releases the line and turns on every selected section, including the peak detectors, together with the data output enables. By then the host must hold the line low itself. If the line reads high at any time while the block is awake, the host has not acknowledged or has let go. The block then powers everything down and starts again from the dark phase. Each time the settle phase begins, the block sends a start pulse to the polling timer calibration engine, and also to the FSK receiver calibration engine if that baseband is selected. When polling mode is off, the block runs the receiver continuously from the module mask and leaves the line alone.

All pins are plain control and status levels or single-cycle strobes. The block has no streaming interface, so no valid/ready handshake or back-pressure applies. Timer counts are sampled when a phase is loaded. A count changed during a phase takes effect at the next load.

Top module: `drx_wake_seq`

## Requirements
- R1: A rising polling enable starts the dark phase. In the dark phase all power enables and data output enables are 0, the line is released and no calibration pulse is issued.
- R2: The dark phase lasts N × 4^P base ticks, where N = {off_hi, off_lo} and P = off_ps (codes 0..3 give 120 µs, 480 µs, 1.92 ms, 7.68 ms). N = 0 lasts one tick. Clock cycles without a tick do not advance any phase.
- R3: When the dark phase ends, the block pulls the line low (line_pull_low = 1). The pull lasts through the whole recovery phase and the whole settle phase, and power stays off during recovery.
- R4: The recovery phase lasts rec_cnt base ticks. A count of 0 lasts one tick.
- R5: The settle phase lasts {rf_hi, rf_lo} base ticks, and a count of 0 lasts one tick. During the settle phase pwr_en equals mod_mask with the peak detector bits (bit 4 ASK peak, bit 6 FSK peak) forced to 0, and data_oe is 0.
- R6: When the settle phase ends, the line is released, pwr_en equals mod_mask, and data_oe = {mod_mask[5], mod_mask[3]} (bit 1 FSK data, bit 0 ASK data). The mask bit order is 0 LNA, 1 AGC, 2 mixer, 3 ASK baseband, 4 ASK peak, 5 FSK baseband, 6 FSK peak.
- R7: If line_in is high while the block is awake, the next cycle is a new dark phase with everything powered down. This covers a host that never acknowledged.
- R8: While the host holds the line low, the block stays awake with all selected sections and data outputs on.
- R9: In the first settle-phase cycle cal_poll_start pulses for exactly one cycle. cal_rx_start pulses in the same cycle only if mod_mask[5] is set.
- R10: With polling disabled, one cycle after drx_en is low the block releases the line, drives pwr_en = mod_mask and data_oe as in R6, and issues no calibration pulses. Ticks and line activity have no effect in this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse every 120 µs base period |
| drx_en | input | 1 | Polling (discontinuous receive) mode enable |
| off_hi | input | 8 | Dark phase count, upper byte |
| off_lo | input | 8 | Dark phase count, lower byte |
| off_ps | input | 2 | Dark phase time base select |
| rec_cnt | input | 8 | Host recovery count in base ticks |
| rf_hi | input | 8 | Settle count, upper byte |
| rf_lo | input | 8 | Settle count, lower byte |
| mod_mask | input | 7 | Receiver sections selected for power |
| line_in | input | 1 | Sampled level of the shared wake line |
| line_pull_low | output | 1 | Enables the open-drain pull-down on the wake line |
| pwr_en | output | 7 | Per-section power enables |
| data_oe | output | 2 | Data output enables (bit 1 FSK, bit 0 ASK) |
| cal_poll_start | output | 1 | Polling timer calibration start pulse |
| cal_rx_start | output | 1 | FSK receiver calibration start pulse |

## Verification
If the phase state is wrong, the power pattern or the pull-down shows it within one cycle. Examples are sections powered in the dark phase, peak detectors powered while the line is still pulled, or data enabled too early. If the shared tick counter is wrong, a phase is stretched or cut short. That shows up as a miscount of ticks between two visible port transitions: the pull-down rising, the calibration pulse, or the release. An error in the acknowledge logic shows on the cycle after the line goes high while awake, because the block either stays powered or fails to go dark.

// File: rtl/drx_seq_pkg.sv
package drx_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_OFF     = 3'd1,
    ST_HOSTREC = 3'd2,
    ST_SETTLE  = 3'd3,
    ST_AWAKE   = 3'd4
  } drx_state_e;

  localparam int N_MOD    = 7;
  localparam int M_LNA    = 0;
  localparam int M_AGC    = 1;
  localparam int M_MIX    = 2;
  localparam int M_ASK_BB = 3;
  localparam int M_ASK_PK = 4;
  localparam int M_FSK_BB = 5;
  localparam int M_FSK_PK = 6;

  localparam logic [N_MOD-1:0] PEAK_MASK =
    (N_MOD'(1) << M_ASK_PK) | (N_MOD'(1) << M_FSK_PK);

endpackage

// File: rtl/drx_len_calc.sv
module drx_len_calc #(
  parameter int CNT_W    = 16,
  parameter int REC_W    = 8,
  parameter int PS_W     = 2,
  parameter int PS_SHIFT = 2,
  parameter int REM_W    = CNT_W + PS_SHIFT * ((1 << PS_W) - 1)
) (
  input  logic [CNT_W-1:0] off_cnt,
  input  logic [PS_W-1:0]  off_ps,
  input  logic [REC_W-1:0] rec_cnt,
  input  logic [CNT_W-1:0] rf_cnt,
  output logic [REM_W-1:0] off_len,
  output logic [REM_W-1:0] rec_len,
  output logic [REM_W-1:0] rf_len
);

  localparam int N_PS = 1 << PS_W;
  localparam logic [REM_W-1:0] ONE = REM_W'(1);

  logic [REM_W-1:0] off_ext;
  logic [REM_W-1:0] off_opts [N_PS];

  assign off_ext = {{(REM_W-CNT_W){1'b0}}, off_cnt};

  // one scaled copy per time base code
  for (genvar g = 0; g < N_PS; g++) begin : g_base
    assign off_opts[g] = off_ext << (PS_SHIFT * g);
  end

  assign off_len = (off_cnt == '0) ? ONE : off_opts[off_ps];
  assign rec_len = (rec_cnt == '0) ? ONE : {{(REM_W-REC_W){1'b0}}, rec_cnt};
  assign rf_len  = (rf_cnt  == '0) ? ONE : {{(REM_W-CNT_W){1'b0}}, rf_cnt};

endmodule

// File: rtl/drx_phase_timer.sv
module drx_phase_timer #(
  parameter int REM_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REM_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);

  logic [REM_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= REM_W'(1);
    end else if (load) begin
      rem_q <= load_val;
    end else if (run && tick && rem_q != REM_W'(1)) begin
      rem_q <= rem_q - REM_W'(1);
    end
  end

  assign expire = run && tick && (rem_q == REM_W'(1));

  AST_REM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> rem_q != '0);  // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !load) |=> $stable(rem_q));  // R2

endmodule

// File: rtl/drx_out_map.sv
module drx_out_map
  import drx_seq_pkg::*;
(
  input  drx_state_e       state,
  input  logic [N_MOD-1:0] mask,
  output logic             pull_low,
  output logic [N_MOD-1:0] pwr,
  output logic [1:0]       data_oe
);

  logic full_on;
  logic settle;

  assign full_on  = (state == ST_IDLE) || (state == ST_AWAKE);
  assign settle   = (state == ST_SETTLE);
  assign pull_low = (state == ST_HOSTREC) || settle;

  // peak detectors wait for the end of settling, other sections come up at its start
  for (genvar g = 0; g < N_MOD; g++) begin : g_pwr
    if (PEAK_MASK[g]) begin : g_peak
      assign pwr[g] = mask[g] & full_on;
    end else begin : g_main
      assign pwr[g] = mask[g] & (full_on | settle);
    end
  end

  assign data_oe = full_on ? {mask[M_FSK_BB], mask[M_ASK_BB]} : 2'b00;

endmodule

// File: rtl/drx_wake_seq.sv
module drx_wake_seq
  import drx_seq_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int PS_W     = 2,
  parameter int PS_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              drx_en,
  input  logic [BYTE_W-1:0] off_hi,
  input  logic [BYTE_W-1:0] off_lo,
  input  logic [PS_W-1:0]   off_ps,
  input  logic [BYTE_W-1:0] rec_cnt,
  input  logic [BYTE_W-1:0] rf_hi,
  input  logic [BYTE_W-1:0] rf_lo,
  input  logic [N_MOD-1:0]  mod_mask,
  input  logic              line_in,
  output logic              line_pull_low,
  output logic [N_MOD-1:0]  pwr_en,
  output logic [1:0]        data_oe,
  output logic              cal_poll_start,
  output logic              cal_rx_start
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam int REM_W = CNT_W + PS_SHIFT * ((1 << PS_W) - 1);

  drx_state_e       state_q, state_d;
  logic             tmr_load, tmr_run, tmr_expire;
  logic [REM_W-1:0] tmr_val;
  logic [REM_W-1:0] off_len, rec_len, rf_len;
  logic             poll_q, rx_q;

  drx_len_calc #(
    .CNT_W(CNT_W), .REC_W(BYTE_W), .PS_W(PS_W), .PS_SHIFT(PS_SHIFT), .REM_W(REM_W)
  ) u_len (
    .off_cnt ({off_hi, off_lo}),
    .off_ps  (off_ps),
    .rec_cnt (rec_cnt),
    .rf_cnt  ({rf_hi, rf_lo}),
    .off_len (off_len),
    .rec_len (rec_len),
    .rf_len  (rf_len)
  );

  assign tmr_run = (state_q == ST_OFF) || (state_q == ST_HOSTREC) ||
                   (state_q == ST_SETTLE);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    if (!drx_en) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_d  = ST_OFF;
          tmr_load = 1'b1;
        end
        ST_OFF: if (tmr_expire) begin
          state_d  = ST_HOSTREC;
          tmr_load = 1'b1;
        end
        ST_HOSTREC: if (tmr_expire) begin
          state_d  = ST_SETTLE;
          tmr_load = 1'b1;
        end
        ST_SETTLE: if (tmr_expire) begin
          state_d = ST_AWAKE;
        end
        ST_AWAKE: if (line_in) begin
          state_d  = ST_OFF;
          tmr_load = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_d)
      ST_OFF:     tmr_val = off_len;
      ST_HOSTREC: tmr_val = rec_len;
      ST_SETTLE:  tmr_val = rf_len;
      default:    tmr_val = '0;
    endcase
  end

  drx_phase_timer #(.REM_W(REM_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .tick     (tick),
    .expire   (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      poll_q  <= 1'b0;
      rx_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      poll_q  <= drx_en && (state_q == ST_HOSTREC) && tmr_expire;
      rx_q    <= drx_en && (state_q == ST_HOSTREC) && tmr_expire && mod_mask[M_FSK_BB];
    end
  end

  assign cal_poll_start = poll_q;
  assign cal_rx_start   = rx_q;

  drx_out_map u_map (
    .state    (state_q),
    .mask     (mod_mask),
    .pull_low (line_pull_low),
    .pwr      (pwr_en),
    .data_oe  (data_oe)
  );

  AST_PULL_FROM_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_pull_low) |-> $past(pwr_en) == '0);  // R3

  AST_SETTLE_NO_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_low |-> ((pwr_en & PEAK_MASK) == '0 && data_oe == 2'b00));  // R5

  AST_RESTART_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (drx_en && !line_pull_low && line_in && $past(line_pull_low)) |=>
      (pwr_en == '0 || !drx_en));  // R7

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_poll_start |=> !cal_poll_start);  // R9

  AST_STROBE_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_poll_start |-> line_pull_low);  // R9

  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cal_rx_start |-> cal_poll_start);  // R9

  AST_CONT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !drx_en |=> (!line_pull_low && !cal_poll_start));  // R10

endmodule

// File: tb/drx_wake_seq_tb.sv
module drx_wake_seq_tb;

  localparam logic [6:0] PEAK = 7'b1010000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       drx_en = 1'b0;
  logic [7:0] off_hi = '0, off_lo = '0, rec_cnt = '0, rf_hi = '0, rf_lo = '0;
  logic [1:0] off_ps = '0;
  logic [6:0] mod_mask = 7'h2B;
  logic       host_low = 1'b0;
  logic       line_in;
  logic       line_pull_low, cal_poll_start, cal_rx_start;
  logic [6:0] pwr_en;
  logic [1:0] data_oe;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign line_in = (line_pull_low || host_low) ? 1'b0 : 1'b1;

  drx_wake_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .drx_en(drx_en),
    .off_hi(off_hi), .off_lo(off_lo), .off_ps(off_ps), .rec_cnt(rec_cnt),
    .rf_hi(rf_hi), .rf_lo(rf_lo), .mod_mask(mod_mask), .line_in(line_in),
    .line_pull_low(line_pull_low), .pwr_en(pwr_en), .data_oe(data_oe),
    .cal_poll_start(cal_poll_start), .cal_rx_start(cal_rx_start)
  );

  function automatic int exp_len(input int n, input int sh);
    return (n == 0) ? 1 : (n << sh);
  endfunction

  function automatic logic [1:0] exp_oe(input logic [6:0] m);
    return {m[5], m[3]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one wake cycle; entry: outputs are in (or entering) the dark phase
  task automatic do_wake(input bit ack, input int hold);
    int off_t = 0, rec_t = 0, set_t = 0;
    bit seen = 0, reached = 0, bad_off = 0, bad_rec = 0, bad_set = 0;
    int ph;
    for (int cyc = 0; cyc < 40000; cyc++) begin
      @(negedge clk);
      if (!line_pull_low && seen) begin reached = 1; break; end
      if (cal_poll_start) begin
        seen = 1;
        chk(cal_rx_start == mod_mask[5], "R9 rx strobe", cal_rx_start, mod_mask[5]);
      end
      if (line_pull_low && !seen) begin
        ph = 1;
        if (pwr_en != 0 || data_oe != 0) bad_rec = 1;
      end else if (line_pull_low) begin
        ph = 2;
        if (pwr_en != (mod_mask & ~PEAK) || data_oe != 0) bad_set = 1;
        if (ack) host_low = 1'b1;
      end else begin
        ph = 0;
        if (pwr_en != 0 || data_oe != 0 || cal_poll_start || cal_rx_start) bad_off = 1;
      end
      tick = 1'($urandom_range(0, 1));
      if (tick) begin
        if (ph == 0) off_t++; else if (ph == 1) rec_t++; else set_t++;
      end
    end
    tick = 1'b0;
    chk(reached, "R3 wake reached", reached, 1);
    chk(!bad_off, "R1 dark outputs", bad_off, 0);
    chk(!bad_rec, "R3 recovery outputs", bad_rec, 0);
    chk(!bad_set, "R5 settle outputs", bad_set, 0);
    chk(off_t == exp_len({off_hi, off_lo}, 2 * off_ps), "R2 dark ticks",
        off_t, exp_len({off_hi, off_lo}, 2 * off_ps));
    chk(rec_t == exp_len(rec_cnt, 0), "R4 recovery ticks", rec_t, exp_len(rec_cnt, 0));
    chk(set_t == exp_len({rf_hi, rf_lo}, 0), "R5 settle ticks", set_t, exp_len({rf_hi, rf_lo}, 0));
    chk(pwr_en == mod_mask, "R6 awake power", pwr_en, mod_mask);
    chk(data_oe == exp_oe(mod_mask), "R6 awake data", data_oe, exp_oe(mod_mask));
    if (ack) begin
      for (int k = 0; k < hold; k++) begin
        tick = 1'($urandom_range(0, 1));
        @(negedge clk);
        chk(pwr_en == mod_mask && !line_pull_low, "R8 held awake", pwr_en, mod_mask);
      end
      tick = 1'b0;
      host_low = 1'b0;
    end
    @(negedge clk);
    chk(pwr_en == 0 && !line_pull_low && data_oe == 0, "R7 restart dark", pwr_en, 0);
  endtask

  task automatic scn(input logic [15:0] off, input logic [1:0] ps, input logic [7:0] rc,
                     input logic [15:0] rf, input logic [6:0] m, input bit ack, input int hold);
    @(negedge clk);
    drx_en = 1'b0; tick = 1'b0; host_low = 1'b0;
    {off_hi, off_lo} = off; off_ps = ps; rec_cnt = rc; {rf_hi, rf_lo} = rf; mod_mask = m;
    @(negedge clk);
    drx_en = 1'b1;
    do_wake(ack, hold);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    bit bad;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!line_pull_low && !cal_poll_start && !cal_rx_start, "R10 reset released", line_pull_low, 0);
    chk(pwr_en == mod_mask, "R10 reset power", pwr_en, mod_mask);

    // continuous mode ignores ticks and line activity
    bad = 0;
    for (int k = 0; k < 30; k++) begin
      tick = 1'($urandom_range(0, 1));
      host_low = 1'($urandom_range(0, 1));
      @(negedge clk);
      if (line_pull_low || pwr_en != mod_mask || data_oe != exp_oe(mod_mask) ||
          cal_poll_start || cal_rx_start) bad = 1;
    end
    chk(!bad, "R10 continuous mode", bad, 0);
    tick = 1'b0; host_low = 1'b0;

    // directed corners
    scn(16'd0, 2'd0, 8'd0, 16'd0, 7'h7F, 1'b1, 5);  // all zero counts
    scn(16'd1, 2'd3, 8'd2, 16'd3, 7'h5D, 1'b0, 0);  // largest base, no ack
    do_wake(1'b0, 0);                                // repeats after restart
    scn(16'd5, 2'd1, 8'd1, 16'd4, 7'h17, 1'b1, 3);  // no FSK baseband
    scn(16'd3, 2'd2, 8'd7, 16'd0, 7'h20, 1'b1, 0);

    // random configurations
    for (int it = 0; it < 8; it++) begin
      scn(16'($urandom_range(0, 20)), 2'($urandom_range(0, 3)), 8'($urandom_range(0, 10)),
          16'($urandom_range(0, 30)), 7'($urandom_range(1, 127)),
          1'($urandom_range(0, 1)), $urandom_range(0, 5));
    end

    // drop polling mid-recovery
    @(negedge clk);
    drx_en = 1'b0;
    {off_hi, off_lo} = 16'd1; off_ps = 2'd0; rec_cnt = 8'd50; mod_mask = 7'h3C;
    @(negedge clk);
    drx_en = 1'b1;
    for (int k = 0; k < 200 && !line_pull_low; k++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
    chk(line_pull_low, "R3 pull seen", line_pull_low, 1);
    drx_en = 1'b0;
    @(negedge clk);
    chk(!line_pull_low && pwr_en == mod_mask, "R10 drop mid cycle", pwr_en, mod_mask);
    chk(data_oe == exp_oe(mod_mask), "R10 drop data", data_oe, exp_oe(mod_mask));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule